// File: doc/BRIEF.md
# Late-Write Synchronous SRAM Core

This block is a pipelined synchronous static memory that holds 36-bit words, each split into four 9-bit byte lanes. Every control input is captured on the rising clock edge: chip select, write enable, the four active-low byte write enables and the address. A read places its word on the data-out bus for the cycle that follows the edge at which it was sampled. A write uses late data: the word for a write sampled at edge E is taken from the data-in bus at edge E+1. The pending write is held in a write-address/data register and reaches the array only when the next write command is accepted.

Because the array lags behind the last write, an address comparator checks each read against the held write. On a match, the enabled bytes of the pending word are merged into the array word. A small state machine tracks the pending write. Its states are PW_EMPTY (nothing pending), PW_CAPTURE (a write was accepted at the last edge and its data is on the bus now) and PW_HELD (a complete write is held). Its transitions are: any state goes to PW_CAPTURE on a write command; PW_CAPTURE goes to PW_HELD on a read or deselect; PW_HELD and PW_EMPTY stay put on a read or deselect. A second machine drives the output flag. Its states are OS_FLOAT and OS_DRIVE. It enters OS_DRIVE on a read command and OS_FLOAT on any other command.

The output-valid flag stands in for the tri-state enable of a pad. The output-enable input and the sleep input both clear the flag without waiting for a clock edge.

Top module: `late_write_sram`

## Requirements
- R1: A word written with a write command at edge E and data presented on `din` at edge E+1 is returned unchanged by any later read of that address.
- R2: In the cycle after a write command edge, `dout_valid` is 0.
- R3: A read command (cs_n=0, we_n=1) sampled at edge E sets `dout_valid` to 1 and puts the addressed word on `dout` from just after E until the next edge, provided oe_n=0 and sleep=0.
- R4: bwe_n[i]=0 enables byte lane i, which is bits [9i+8:9i]. A write changes only its enabled lanes, and a write with bwe_n=4'b1111 leaves the word unchanged.
- R5: With cs_n=1 at an edge, the following cycle has `dout_valid`=0 and nothing is written, even if we_n=0 and bwe_n=0.
- R6: oe_n=1 clears `dout_valid` at once, without a clock edge. A read sampled while oe_n=1 is a dummy read. Setting oe_n back to 0 within the same cycle brings back the read word.
- R7: sleep=1 forces `dout_valid` to 0 whatever the other inputs are.
- R8: A read of the address of a pending write returns that write's enabled bytes merged over the array word. This also holds when the read comes in the very cycle the write data is on `din`.
- R9: A pending write survives any number of read or deselect cycles. It is committed to the array only at the edge of the next accepted write.
- R10: While rst_n=0, and after it is released, `dout_valid` is 0 and no write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep | input | 1 | Power-down request; forces the output flag low |
| cs_n | input | 1 | Active-low chip select, sampled at the edge |
| we_n | input | 1 | Active-low write command, sampled at the edge |
| bwe_n | input | NBYTE | Active-low byte write enables, lane i = bits [9i+8:9i] |
| oe_n | input | 1 | Active-low output enable, acts without the clock |
| addr | input | ADDR_W | Word address, sampled at the edge |
| din | input | NBYTE*BYTE_W | Write data, one edge after its write command |
| dout | output | NBYTE*BYTE_W | Registered read data |
| dout_valid | output | 1 | Output drive enable (1 = data driven) |

## Verification
Runs of back-to-back writes followed by reads separate a correct late-data capture from a capture taken one edge early or late. Partial byte masks, including the all-disabled mask, show whether the lanes are decoded in the stated bit order. Reads placed in the same cycle as the write data, and again after the write has moved to the held state, exercise the two forwarding sources on their own. A write followed by long runs of deselects and unrelated reads, and only later by another write, shows whether the held word is lost or committed too early. Dummy reads, an output-enable change in the middle of a cycle, and sleep cycles separate the asynchronous gating of the flag from the registered drive state.

// File: rtl/lws_pkg.sv
package lws_pkg;
    typedef enum logic [1:0] {
        OP_NOP   = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    typedef enum logic [1:0] {
        PW_EMPTY   = 2'd0,
        PW_CAPTURE = 2'd1,
        PW_HELD    = 2'd2
    } pw_state_e;

    typedef enum logic {
        OS_FLOAT = 1'b0,
        OS_DRIVE = 1'b1
    } out_state_e;
endpackage

// File: rtl/lws_array.sv
module lws_array #(
    parameter int ADDR_W = 6,
    parameter int NBYTE  = 4,
    parameter int BYTE_W = 9
) (
    input  logic                      clk,
    input  logic                      we,
    input  logic [NBYTE-1:0]          wmask,
    input  logic [ADDR_W-1:0]         waddr,
    input  logic [NBYTE*BYTE_W-1:0]   wdata,
    input  logic [ADDR_W-1:0]         raddr,
    output logic [NBYTE*BYTE_W-1:0]   rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < NBYTE; g++) begin : g_lane
        logic [BYTE_W-1:0] lane [DEPTH];

        always_ff @(posedge clk) begin
            if (we && wmask[g]) begin
                lane[waddr] <= wdata[g*BYTE_W +: BYTE_W];
            end
        end

        assign rdata[g*BYTE_W +: BYTE_W] = lane[raddr];
    end
endmodule

// File: rtl/lws_pending.sv
module lws_pending
    import lws_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int NBYTE  = 4,
    parameter int BYTE_W = 9
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  op_e                       op,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [NBYTE-1:0]          be_n,
    input  logic [NBYTE*BYTE_W-1:0]   din,
    input  logic [NBYTE*BYTE_W-1:0]   arr_word,
    output logic                      commit_en,
    output logic [ADDR_W-1:0]         commit_addr,
    output logic [NBYTE-1:0]          commit_mask,
    output logic [NBYTE*BYTE_W-1:0]   commit_data,
    output logic [NBYTE*BYTE_W-1:0]   rd_word
);
    localparam int WORD_W = NBYTE * BYTE_W;

    pw_state_e           state_q, state_d;
    logic [ADDR_W-1:0]   wa_q;
    logic [NBYTE-1:0]    be1_q, be2_q;
    logic [WORD_W-1:0]   wd_q;
    logic [WORD_W-1:0]   pend_data;
    logic [NBYTE-1:0]    pend_mask;
    logic                hit;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PW_EMPTY;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PW_EMPTY:   state_d = (op == OP_WRITE) ? PW_CAPTURE : PW_EMPTY;
            PW_CAPTURE: state_d = (op == OP_WRITE) ? PW_CAPTURE : PW_HELD;
            PW_HELD:    state_d = (op == OP_WRITE) ? PW_CAPTURE : PW_HELD;
            default:    state_d = PW_EMPTY;
        endcase
    end

    // write address, two byte-enable stages, data register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wa_q  <= '0;
            be1_q <= '0;
            be2_q <= '0;
            wd_q  <= '0;
        end else begin
            if (op == OP_WRITE) begin
                wa_q  <= addr;
                be1_q <= ~be_n;
            end
            if (state_q == PW_CAPTURE) begin
                wd_q  <= din;
                be2_q <= be1_q;
            end
        end
    end

    // pending word source and outputs
    always_comb begin
        pend_data   = (state_q == PW_CAPTURE) ? din   : wd_q;
        pend_mask   = (state_q == PW_CAPTURE) ? be1_q : be2_q;
        commit_en   = (op == OP_WRITE) && (state_q != PW_EMPTY);
        commit_addr = wa_q;
        commit_mask = pend_mask;
        commit_data = pend_data;
        hit         = (state_q != PW_EMPTY) && (addr == wa_q);
    end

    for (genvar g = 0; g < NBYTE; g++) begin : g_merge
        assign rd_word[g*BYTE_W +: BYTE_W] = (hit && pend_mask[g])
            ? pend_data[g*BYTE_W +: BYTE_W]
            : arr_word[g*BYTE_W +: BYTE_W];
    end

    // R1: capture state only ever follows an accepted write
    p_capture_after_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PW_CAPTURE) |-> $past(op == OP_WRITE));

    // R9: held word and address do not move while no write arrives
    p_held_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PW_HELD && op != OP_WRITE) |=> ($stable(wd_q) && $stable(wa_q)));

    // R9: held state is never entered on a write edge
    p_held_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PW_HELD) |-> $past(op != OP_WRITE));
endmodule

// File: rtl/late_write_sram.sv
module late_write_sram
    import lws_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int NBYTE  = 4,
    parameter int BYTE_W = 9
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sleep,
    input  logic                      cs_n,
    input  logic                      we_n,
    input  logic [NBYTE-1:0]          bwe_n,
    input  logic                      oe_n,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [NBYTE*BYTE_W-1:0]   din,
    output logic [NBYTE*BYTE_W-1:0]   dout,
    output logic                      dout_valid
);
    localparam int WORD_W = NBYTE * BYTE_W;

    op_e                 op;
    out_state_e          os_q, os_d;
    logic [WORD_W-1:0]   dout_q;
    logic [WORD_W-1:0]   arr_word, rd_word, commit_data;
    logic                commit_en;
    logic [ADDR_W-1:0]   commit_addr;
    logic [NBYTE-1:0]    commit_mask;

    // command decode
    always_comb begin
        if (cs_n)      op = OP_NOP;
        else if (!we_n) op = OP_WRITE;
        else           op = OP_READ;
    end

    lws_pending #(.ADDR_W(ADDR_W), .NBYTE(NBYTE), .BYTE_W(BYTE_W)) u_pend (
        .clk         (clk),
        .rst_n       (rst_n),
        .op          (op),
        .addr        (addr),
        .be_n        (bwe_n),
        .din         (din),
        .arr_word    (arr_word),
        .commit_en   (commit_en),
        .commit_addr (commit_addr),
        .commit_mask (commit_mask),
        .commit_data (commit_data),
        .rd_word     (rd_word)
    );

    lws_array #(.ADDR_W(ADDR_W), .NBYTE(NBYTE), .BYTE_W(BYTE_W)) u_arr (
        .clk   (clk),
        .we    (commit_en),
        .wmask (commit_mask),
        .waddr (commit_addr),
        .wdata (commit_data),
        .raddr (addr),
        .rdata (arr_word)
    );

    // output drive state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) os_q <= OS_FLOAT;
        else        os_q <= os_d;
    end

    always_comb begin
        os_d = os_q;
        unique case (os_q)
            OS_FLOAT: os_d = (op == OP_READ) ? OS_DRIVE : OS_FLOAT;
            OS_DRIVE: os_d = (op == OP_READ) ? OS_DRIVE : OS_FLOAT;
            default:  os_d = OS_FLOAT;
        endcase
    end

    // output latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              dout_q <= '0;
        else if (op == OP_READ)  dout_q <= rd_word;
    end

    always_comb begin
        dout       = dout_q;
        dout_valid = (os_q == OS_DRIVE) && !oe_n && !sleep;
    end

    p_write_float_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !we_n) |=> !dout_valid);

    p_desel_float_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !dout_valid);

    p_oe_float_r6: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dout_valid);

    p_sleep_float_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !dout_valid);

    p_commit_on_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        commit_en |-> (!cs_n && !we_n));
endmodule

// File: tb/sim_late_write_sram.sv
module sim_late_write_sram;
    localparam int AW = 6;
    localparam int W  = 36;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sleep = 1'b0;
    logic          cs_n = 1'b1;
    logic          we_n = 1'b1;
    logic [3:0]    bwe_n = 4'hF;
    logic          oe_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [W-1:0]  din = '0;
    logic [W-1:0]  dout;
    logic          dout_valid;

    int n_chk = 0;
    int n_fail = 0;

    logic [W-1:0]  refm [1<<AW];
    logic          pw = 1'b0;
    logic [AW-1:0] pa = '0;
    logic [3:0]    pb = 4'hF;

    always #10 clk = ~clk;

    late_write_sram u0 (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .cs_n(cs_n), .we_n(we_n),
        .bwe_n(bwe_n), .oe_n(oe_n), .addr(addr), .din(din),
        .dout(dout), .dout_valid(dout_valid)
    );

    task automatic chk(input logic ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] merge(input logic [W-1:0] old, input logic [W-1:0] nw, input logic [3:0] ben);
        logic [W-1:0] r = old;
        for (int i = 0; i < 4; i++)
            if (!ben[i]) r[i*9 +: 9] = nw[i*9 +: 9];
        return r;
    endfunction

    // one clock step, called at a falling edge; checks just before the next falling edge
    task automatic step(input logic c, input logic w, input logic [3:0] b,
                        input logic [AW-1:0] a, input logic [W-1:0] d, input string tag);
        logic          ev;
        logic [W-1:0]  ed;
        cs_n = c; we_n = w; bwe_n = b; addr = a; din = d;
        if (pw) refm[pa] = merge(refm[pa], d, pb);
        ev = !c && w && !oe_n && !sleep;
        ed = refm[a];
        pw = !c && !w; pa = a; pb = b;
        @(posedge clk);
        @(negedge clk);
        chk(dout_valid == ev, {tag, " valid"}, {35'd0, dout_valid}, {35'd0, ev});
        if (ev) chk(dout == ed, {tag, " data"}, dout, ed);
    endtask

    function automatic logic [W-1:0] pat(input int i);
        return {4'(i), 32'hC3A5_0000 + 32'(i * 32'h1F3)};
    endfunction

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(dout_valid == 1'b0, "R10 reset flag", {35'd0, dout_valid}, '0);
        rst_n = 1'b1;
        step(1'b1, 1'b1, 4'hF, '0, '0, "R10 after release");
    endtask

    task automatic t_fill;
        step(1'b0, 1'b0, 4'h0, 6'd0, '0, "R2 write 0");
        for (int i = 1; i < 8; i++) step(1'b0, 1'b0, 4'h0, 6'(i), pat(i - 1), "R2 write run");
        step(1'b1, 1'b1, 4'hF, '0, pat(7), "R5 deselect after writes");
        for (int i = 0; i < 8; i++) step(1'b0, 1'b1, 4'hF, 6'(i), '0, "R1 R3 readback");
    endtask

    task automatic t_bytes;
        step(1'b0, 1'b0, 4'b1010, 6'd3, '0, "R4 partial write");
        step(1'b1, 1'b1, 4'hF, '0, 36'hF_FFFF_FFFF, "R4 data");
        step(1'b0, 1'b0, 4'b1111, 6'd5, '0, "R4 no-lane write");
        step(1'b0, 1'b0, 4'b0111, 6'd6, 36'h1_2345_6789, "R4 top-lane write");
        step(1'b1, 1'b1, 4'hF, '0, 36'h9_ABCD_EF01, "R4 data");
        step(1'b0, 1'b1, 4'hF, 6'd3, '0, "R4 lanes 0,2 only");
        step(1'b0, 1'b1, 4'hF, 6'd5, '0, "R4 unchanged word");
        step(1'b0, 1'b1, 4'hF, 6'd6, '0, "R4 lane 3 only");
        step(1'b1, 1'b0, 4'h0, 6'd7, '0, "R5 deselect with write");
        step(1'b0, 1'b0, 4'h0, 6'd9, 36'hD_EAD0_BEEF, "R5 next write");
        step(1'b1, 1'b1, 4'hF, '0, 36'h0_1111_2222, "R5 data");
        step(1'b0, 1'b1, 4'hF, 6'd7, '0, "R5 nothing written");
    endtask

    task automatic t_forward;
        step(1'b0, 1'b0, 4'h0, 6'd10, '0, "R8 write 10");
        step(1'b0, 1'b1, 4'hF, 6'd10, 36'hA_5A5A_5A5A, "R8 read on data cycle");
        step(1'b0, 1'b1, 4'hF, 6'd10, '0, "R8 read from held");
        step(1'b0, 1'b0, 4'b0110, 6'd1, '0, "R8 partial write 1");
        step(1'b0, 1'b1, 4'hF, 6'd1, 36'h3_3333_3333, "R8 merged on data cycle");
        step(1'b1, 1'b1, 4'hF, '0, '0, "R8 gap");
        step(1'b0, 1'b1, 4'hF, 6'd1, '0, "R8 merged from held");
        step(1'b0, 1'b1, 4'hF, 6'd2, '0, "R8 other address");
    endtask

    task automatic t_hold;
        step(1'b0, 1'b0, 4'h0, 6'd20, '0, "R9 write 20");
        step(1'b1, 1'b1, 4'hF, '0, 36'h2_0202_0202, "R9 data");
        for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 4'hF, '0, '0, "R9 deselect run");
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 4'hF, 6'(i), '0, "R9 unrelated read");
        step(1'b0, 1'b1, 4'hF, 6'd20, '0, "R9 still pending");
        step(1'b0, 1'b0, 4'h0, 6'd21, '0, "R9 commit 20");
        step(1'b0, 1'b0, 4'h0, 6'd22, 36'h2_1212_1212, "R9 commit 21");
        step(1'b1, 1'b1, 4'hF, '0, 36'h2_2222_2222, "R9 data 22");
        step(1'b0, 1'b1, 4'hF, 6'd20, '0, "R9 read 20");
        step(1'b0, 1'b1, 4'hF, 6'd21, '0, "R9 read 21");
        step(1'b0, 1'b1, 4'hF, 6'd22, '0, "R9 read 22");
    endtask

    task automatic t_oe;
        oe_n = 1'b1;
        step(1'b0, 1'b1, 4'hF, 6'd4, '0, "R6 dummy read");
        oe_n = 1'b0;
        #2;
        chk(dout_valid == 1'b1, "R6 async enable", {35'd0, dout_valid}, 36'd1);
        chk(dout == refm[4], "R6 async data", dout, refm[4]);
        oe_n = 1'b1;
        #2;
        chk(dout_valid == 1'b0, "R6 async disable", {35'd0, dout_valid}, '0);
        oe_n = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_sleep;
        sleep = 1'b1;
        step(1'b0, 1'b1, 4'hF, 6'd0, '0, "R7 sleep read");
        sleep = 1'b0;
        #2;
        chk(dout_valid == 1'b1, "R7 wake", {35'd0, dout_valid}, 36'd1);
        sleep = 1'b1;
        #2;
        chk(dout_valid == 1'b0, "R7 sleep async", {35'd0, dout_valid}, '0);
        sleep = 1'b0;
        @(negedge clk);
        step(1'b0, 1'b1, 4'hF, 6'd6, '0, "R7 after sleep");
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_fill();
        t_bytes();
        t_forward();
        t_hold();
        t_oe();
        t_sleep();
        summary();
    end
endmodule